// File: doc/BRIEF.md
# Exception Return Frame Format Checker

When an exception handler returns, the first word popped from the stack holds a 4-bit frame format code. This block reads that code and works out how many more stack words the return sequence has to restore. It accepts exactly two codes. The short frame is used for ordinary exceptions. The long frame is used for frames left by bus errors and address errors. Any other code is a format error. Every frame, short or long, is at least four words.

The surrounding return sequencer does three things:

1. It pulses a strobe together with the format code.
2. It pulses a word strobe once for each further stack word it consumes.
3. It watches the remaining-word count, the done flag and the format-error flag.

The format word itself counts as the first word of the frame. The count loaded after a valid code is therefore one less than the frame length. A short frame is 4 words and a long frame is 29 words. On a bad code the block raises the error flag, presents exception vector number 14 and asks for no further words.

Top module: `frm_ret_check`

## Requirements
- R1: After reset, words_left is 0, restore_done is 0, fmt_error is 0 and err_vector is 0.
- R2: A format strobe with code 0 (short frame), taken while no frame is in progress, gives words_left = 3 one cycle later, with restore_done and fmt_error low.
- R3: A format strobe with code 8 (long frame), taken while no frame is in progress, gives words_left = 28 one cycle later, with restore_done and fmt_error low.
- R4: A format strobe with any code other than 0 or 8, taken while no frame is in progress, gives fmt_error = 1, err_vector = 14, words_left = 0 and restore_done = 0 one cycle later.
- R5: While words_left is nonzero, each cycle with word_stb high lowers words_left by one, and each cycle without it leaves words_left unchanged.
- R6: restore_done rises in the same cycle that words_left reaches 0 through a word strobe. It then stays high until the next accepted format strobe.
- R7: A format strobe arriving while words_left is nonzero is ignored: the count, restore_done and fmt_error behave as if it were absent.
- R8: A word strobe while words_left is 0 (idle, done or error) changes no output.
- R9: A format strobe after a completed frame or a format error clears restore_done and fmt_error and starts a new decode.
- R10: err_vector reads 0 whenever fmt_error is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_stb | input | 1 | Format word present on fmt_code |
| fmt_code | input | 4 | Format field of the popped frame word |
| word_stb | input | 1 | One further stack word consumed |
| restore_done | output | 1 | Frame fully restored |
| fmt_error | output | 1 | Unknown format code seen |
| err_vector | output | 8 | Exception vector number while fmt_error is high, else 0 |
| words_left | output | 5 | Stack words still to restore |

## Verification
The bench sweeps every illegal code and checks the error path. A decoder that accepted a neighbour of 0 or 8 would load a count instead of flagging the error. A design that kept counting after an error would hand out words that do not exist. The bench sends format strobes in the middle of a frame, where a design that restarted would reload the count. It also sends word strobes while idle, done or in error, where a design that underflowed would wrap the count to 31. The bench watches the exact cycle of the last word, so a design that raised done one cycle late, or that left done set after a new strobe, shows up at once.

// File: rtl/frm_pkg.sv
package frm_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_RUN  = 2'd1,
        FS_DONE = 2'd2,
        FS_ERR  = 2'd3
    } frm_state_e;
endpackage

// File: rtl/frm_decode.sv
module frm_decode #(
    parameter int FMT_W       = 4,
    parameter int SHORT_CODE  = 0,
    parameter int LONG_CODE   = 8,
    parameter int SHORT_WORDS = 4,
    parameter int LONG_WORDS  = 29,
    parameter int CW          = 5
) (
    input  logic [FMT_W-1:0] code,
    output logic             known,
    output logic [CW-1:0]    tail
);
    // tail excludes the format word, which is already consumed
    always_comb begin
        known = 1'b0;
        tail  = '0;
        if (code == FMT_W'(SHORT_CODE)) begin
            known = 1'b1;
            tail  = CW'(SHORT_WORDS - 1);
        end else if (code == FMT_W'(LONG_CODE)) begin
            known = 1'b1;
            tail  = CW'(LONG_WORDS - 1);
        end
    end
endmodule

// File: rtl/frm_count.sv
module frm_count #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          last
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.cnt = load_val;
        end else if (dec && cnt_q.cnt != '0) begin
            cnt_d.cnt = cnt_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q.cnt;
    assign last = dec && !load && (cnt_q.cnt == CW'(1));

    // R5: one word strobe takes exactly one off the count
    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

    // R5: without load or strobe the count holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt));

    // R8: strobe at zero does not wrap
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/frm_ret_check.sv
module frm_ret_check #(
    parameter int FMT_W       = 4,
    parameter int SHORT_CODE  = 0,
    parameter int LONG_CODE   = 8,
    parameter int SHORT_WORDS = 4,
    parameter int LONG_WORDS  = 29,
    parameter int ERR_VECTOR  = 14,
    parameter int VEC_W       = 8,
    localparam int CW         = $clog2(LONG_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fmt_stb,
    input  logic [FMT_W-1:0] fmt_code,
    input  logic             word_stb,
    output logic             restore_done,
    output logic             fmt_error,
    output logic [VEC_W-1:0] err_vector,
    output logic [CW-1:0]    words_left
);
    import frm_pkg::*;

    typedef struct packed {
        frm_state_e       state;
        logic             done;
        logic             err;
        logic [VEC_W-1:0] vec;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic          known;
    logic [CW-1:0] tail;
    logic          busy;
    logic          accept;
    logic          last;

    frm_decode #(
        .FMT_W(FMT_W), .SHORT_CODE(SHORT_CODE), .LONG_CODE(LONG_CODE),
        .SHORT_WORDS(SHORT_WORDS), .LONG_WORDS(LONG_WORDS), .CW(CW)
    ) u_decode (
        .code (fmt_code),
        .known(known),
        .tail (tail)
    );

    assign busy   = (ctl_q.state == FS_RUN);
    assign accept = fmt_stb && !busy;

    frm_count #(.CW(CW)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept && known),
        .load_val(tail),
        .dec     (busy && word_stb),
        .cnt     (words_left),
        .last    (last)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (accept) begin
            ctl_d.done = 1'b0;
            if (known) begin
                ctl_d.state = FS_RUN;
                ctl_d.err   = 1'b0;
                ctl_d.vec   = '0;
            end else begin
                ctl_d.state = FS_ERR;
                ctl_d.err   = 1'b1;
                ctl_d.vec   = VEC_W'(ERR_VECTOR);
            end
        end else if (busy && last) begin
            ctl_d.state = FS_DONE;
            ctl_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{state: FS_IDLE, done: 1'b0, err: 1'b0, vec: '0};
        else        ctl_q <= ctl_d;
    end

    assign restore_done = ctl_q.done;
    assign fmt_error    = ctl_q.err;
    assign err_vector   = ctl_q.vec;

    // R4: unknown code gives error, vector and no words to fetch
    a_r4_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fmt_code != FMT_W'(SHORT_CODE) && fmt_code != FMT_W'(LONG_CODE))
        |=> (fmt_error && err_vector == VEC_W'(ERR_VECTOR) && words_left == '0));

    // R2: short frame count
    a_r2_short_len: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fmt_code == FMT_W'(SHORT_CODE)) |=> (words_left == CW'(SHORT_WORDS - 1)));

    // R3: long frame count
    a_r3_long_len: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fmt_code == FMT_W'(LONG_CODE)) |=> (words_left == CW'(LONG_WORDS - 1)));

    // R6: done only with nothing left
    a_r6_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
        restore_done |-> (words_left == '0));

    // R4: error never requests words and never reports done
    a_r4_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_error |-> (words_left == '0 && !restore_done));

    // R7: mid-frame strobe does not reload
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fmt_stb && !word_stb) |=> $stable(words_left));

    // R10: vector silent without error
    a_r10_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_error |-> (err_vector == '0));
endmodule

// File: tb/frm_ret_check_bench.sv
module frm_ret_check_bench;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fmt_stb;
    logic [3:0]    fmt_code;
    logic          word_stb;
    logic          restore_done;
    logic          fmt_error;
    logic [7:0]    err_vector;
    logic [CW-1:0] words_left;

    always #4 clk = ~clk;

    frm_ret_check u_frm_ret_check (
        .clk(clk), .rst_n(rst_n), .fmt_stb(fmt_stb), .fmt_code(fmt_code),
        .word_stb(word_stb), .restore_done(restore_done), .fmt_error(fmt_error),
        .err_vector(err_vector), .words_left(words_left)
    );

    int checks = 0;
    int fails  = 0;
    int exp_left = 0;
    bit exp_done = 1'b0;
    bit exp_err  = 1'b0;
    bit finished = 1'b0;

    function automatic bit is_known(logic [3:0] c);
        return (c == 4'd0) || (c == 4'd8);
    endfunction

    function automatic int tail_of(logic [3:0] c);
        return (c == 4'd0) ? 3 : 28;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cmp_all(string tag);
        check(tag, "words_left", int'(words_left), exp_left);
        check(tag, "restore_done", int'(restore_done), int'(exp_done));
        check(tag, "fmt_error", int'(fmt_error), int'(exp_err));
        check(tag, "err_vector", int'(err_vector), exp_err ? 14 : 0);
    endtask

    task automatic step(string tag, bit s, logic [3:0] c, bit w);
        bit busy;
        @(negedge clk);
        fmt_stb = s; fmt_code = c; word_stb = w;
        @(posedge clk);
        busy = (exp_left != 0);
        if (s && !busy) begin
            exp_done = 1'b0;
            if (is_known(c)) begin
                exp_left = tail_of(c);
                exp_err  = 1'b0;
            end else begin
                exp_left = 0;
                exp_err  = 1'b1;
            end
        end else if (w && busy) begin
            exp_left--;
            if (exp_left == 0) exp_done = 1'b1;
        end
        #2;
        cmp_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R5 watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; fmt_stb = 1'b0; fmt_code = 4'd0; word_stb = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp_all("R1");
        rst_n = 1'b1;

        // short frame, count down to done
        step("R2", 1'b1, 4'd0, 1'b0);
        step("R5", 1'b0, 4'd0, 1'b1);
        step("R5", 1'b0, 4'd0, 1'b0);
        step("R5", 1'b0, 4'd0, 1'b1);
        step("R6", 1'b0, 4'd0, 1'b1);
        step("R6", 1'b0, 4'd0, 1'b0);
        step("R8", 1'b0, 4'd0, 1'b1);

        // long frame with mid-frame strobes
        step("R3", 1'b1, 4'd8, 1'b0);
        step("R7", 1'b1, 4'd3, 1'b1);
        step("R7", 1'b1, 4'd0, 1'b0);
        step("R7", 1'b1, 4'd8, 1'b1);
        for (int i = 0; i < 26; i++) step("R5", 1'b0, 4'd0, 1'b1);
        step("R6", 1'b0, 4'd0, 1'b0);

        // error path
        step("R4", 1'b1, 4'hF, 1'b0);
        step("R8", 1'b0, 4'd0, 1'b1);
        step("R4", 1'b1, 4'd1, 1'b1);
        step("R9", 1'b1, 4'd0, 1'b0);
        step("R10", 1'b0, 4'd0, 1'b1);
        step("R10", 1'b0, 4'd0, 1'b1);
        step("R10", 1'b0, 4'd0, 1'b1);

        // every illegal code, each followed by recovery
        for (int c = 1; c < 16; c++) begin
            if (c != 8) begin
                step("R4", 1'b1, 4'(c), 1'b0);
                step("R9", 1'b1, 4'd8, 1'b0);
                step("R7", 1'b1, 4'(c), 1'b0);
                for (int k = 0; k < 28; k++) step("R5", 1'b0, 4'd0, 1'b1);
            end
        end

        // constrained random mix
        for (int i = 0; i < 2000; i++) begin
            int r;
            logic [3:0] c;
            r = int'($urandom_range(0, 3));
            c = (r == 0) ? 4'd0 : (r == 1) ? 4'd8 : 4'($urandom_range(0, 15));
            step("R5", ($urandom_range(0, 7) == 0), c, ($urandom_range(0, 1) == 1));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule